// File: doc/BRIEF.md
# Vector Element Slide Unit

This block performs the four element-slide operations of a vector datapath on one register group: shift elements toward higher indices by an offset, shift them toward lower indices by an offset, shift by one toward higher indices while inserting a scalar at the bottom, and shift by one toward lower indices while inserting a scalar at the last active position. The group is a flat vector of `GRP_BITS` bits (`REG_BITS * GROUP_REGS`). It is treated as an array of VLMAX elements at an element width (SEW) of 8, 16, 32 or 64 bits.

The caller presents the old destination contents, the source contents, the active length `vl`, the start index `vstart`, a per-element mask with its enable, the scalar operands and the two register indices. The indices are used only to decide legality. The request travels on a valid/ready channel. One cycle after acceptance the result appears on a valid/ready output channel. The output holds its data until the consumer takes it. The input is ready whenever the output register is empty or is being drained in the same cycle, so back-pressure passes straight through without extra buffering. The block does not read or write the register file.

Top module: `vslide_unit`

## Requirements
- R1: Slide up (op code 0): destination element i with offset <= i < vl receives source element i-offset; elements with i < offset keep their old value.
- R2: Slide down (op code 1): destination element i receives source element i+offset when i+offset < VLMAX, otherwise zero.
- R3: Slide-one up (op code 2): element 0 receives the insert scalar truncated to SEW; element i >= 1 receives source element i-1.
- R4: Slide-one down (op code 3): element i < vl-1 receives source element i+1; element vl-1 receives the insert scalar truncated to SEW.
- R5: With `use_imm`=1 the offset is the 5-bit `imm` zero-extended; otherwise it is the full 64-bit `xoff`, so a value of 2^32 or more is never truncated.
- R6: `sew_sel` codes 0,1,2,3 select SEW 8,16,32,64. VLMAX is GRP_BITS/SEW, and element k occupies bits [k*SEW +: SEW] of each group vector. `vl` never exceeds VLMAX.
- R7: Only element i with vstart <= i < vl and (mask_en=0 or mask bit i = 1) is written; every other element keeps its old value.
- R8: `out_illegal` is raised for the two upward forms when the destination group [vd, vd+GROUP_REGS) overlaps the source group [vs2, vs2+GROUP_REGS). Overlap is legal for the two downward forms.
- R9: `out_illegal` is raised when mask_en=1 and vd index is 0. An illegal operation returns the old destination unchanged.
- R10: The result appears with `out_valid` on the clock edge after `in_valid && in_ready`. While out_valid=1 and out_ready=0, the output holds valid and stable data. in_ready = !out_valid || out_ready.
- R11: After reset, out_valid=0, out_res=0 and out_illegal=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| op | input | 2 | 0 up, 1 down, 2 one-up, 3 one-down |
| use_imm | input | 1 | Offset from imm instead of xoff |
| imm | input | 5 | Unsigned immediate offset |
| xoff | input | 64 | Scalar-register offset |
| scalar | input | 64 | Insert value for the slide-one forms |
| vl | input | VLW | Active length |
| vstart | input | VLW | First element to write |
| sew_sel | input | 2 | Element width code |
| mask | input | MAX_ELEMS | Per-element mask bits |
| mask_en | input | 1 | Masking enabled |
| vd_idx | input | 5 | Destination register index |
| vs2_idx | input | 5 | Source register index |
| old_vd | input | GRP_BITS | Current destination group |
| src | input | GRP_BITS | Source group |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | GRP_BITS | Updated destination group |
| out_illegal | output | 1 | Operation illegal |

## Verification
The checker assumes that every accepted request carries a `vl` no larger than VLMAX for the chosen SEW. One property flags a request that breaks this, since no slide rule defines the elements beyond VLMAX. The stimulus draws `vl` and `vstart` from the range 0..VLMAX of the element width in use. Offsets, register indices and mask bits are drawn freely, and huge scalar offsets are included. Output back-pressure is driven randomly and as a long directed stall, so the hold properties are exercised with real traffic.

// File: rtl/vslide_pkg.sv
package vslide_pkg;
  typedef enum logic [1:0] {
    SLD_UP  = 2'd0,
    SLD_DN  = 2'd1,
    SLD_UP1 = 2'd2,
    SLD_DN1 = 2'd3
  } sld_op_e;

  localparam int REGIDX_W = 5;
  localparam int NUM_SEW  = 4;
  localparam int MIN_SEW  = 8;
endpackage

// File: rtl/vslide_lane.sv
// Computes the full result group for one fixed element width.
module vslide_lane
  import vslide_pkg::*;
#(
  parameter int GRP_BITS  = 256,
  parameter int SEW       = 8,
  parameter int MAX_ELEMS = 32,
  parameter int VLW       = 6
) (
  input  sld_op_e               op,
  input  logic [63:0]           off,
  input  logic [63:0]           scalar,
  input  logic [VLW-1:0]        vl,
  input  logic [VLW-1:0]        vstart,
  input  logic [MAX_ELEMS-1:0]  mask,
  input  logic                  mask_en,
  input  logic [GRP_BITS-1:0]   old_vd,
  input  logic [GRP_BITS-1:0]   src,
  output logic [GRP_BITS-1:0]   res
);
  localparam int ELEMS = GRP_BITS / SEW;
  localparam int IW    = $clog2(ELEMS);

  logic [SEW-1:0] src_e [ELEMS];
  logic [SEW-1:0] old_e [ELEMS];

  for (genvar g = 0; g < ELEMS; g++) begin : g_el
    logic [SEW-1:0] nv;
    logic           act;

    assign src_e[g] = src[g*SEW +: SEW];
    assign old_e[g] = old_vd[g*SEW +: SEW];

    assign act = (int'(vstart) <= g) && (int'(vl) > g) && (!mask_en || mask[g]);

    always_comb begin
      nv = old_e[g];
      case (op)
        SLD_UP: begin
          if (off <= 64'(g)) nv = src_e[IW'(64'(g) - off)];
        end
        SLD_DN: begin
          if (off < 64'(ELEMS - g)) nv = src_e[IW'(64'(g) + off)];
          else                      nv = '0;
        end
        SLD_UP1: begin
          if (g == 0) nv = scalar[SEW-1:0];
          else        nv = src_e[IW'(g + ELEMS - 1)];
        end
        default: begin
          if (int'(vl) == g + 1) nv = scalar[SEW-1:0];
          else                   nv = src_e[IW'(g + 1)];
        end
      endcase
    end

    assign res[g*SEW +: SEW] = act ? nv : old_e[g];
  end
endmodule

// File: rtl/vslide_legal.sv
// Register-index legality: overlap for upward forms, masked write to v0.
module vslide_legal
  import vslide_pkg::*;
#(
  parameter int GROUP_REGS = 2
) (
  input  sld_op_e             op,
  input  logic                mask_en,
  input  logic [REGIDX_W-1:0] vd_idx,
  input  logic [REGIDX_W-1:0] vs2_idx,
  output logic                illegal
);
  localparam int SW = REGIDX_W + 1;

  logic [SW-1:0] vd_lo, vd_hi, vs_lo, vs_hi;
  logic          overlap, upward;

  assign vd_lo   = {1'b0, vd_idx};
  assign vs_lo   = {1'b0, vs2_idx};
  assign vd_hi   = vd_lo + SW'(GROUP_REGS);
  assign vs_hi   = vs_lo + SW'(GROUP_REGS);
  assign overlap = (vd_lo < vs_hi) && (vs_lo < vd_hi);
  assign upward  = (op == SLD_UP) || (op == SLD_UP1);
  assign illegal = (upward && overlap) || (mask_en && (vd_idx == '0));
endmodule

// File: rtl/vslide_outreg.sv
// One-entry output stage with pass-through back-pressure.
module vslide_outreg #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_res,
  input  logic         d_ill,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_res,
  output logic         out_ill
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_ill   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_res   <= d_res;
      out_ill   <= d_ill;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vslide_unit.sv
module vslide_unit
  import vslide_pkg::*;
#(
  parameter int REG_BITS   = 128,
  parameter int GROUP_REGS = 2,
  localparam int GRP_BITS  = REG_BITS * GROUP_REGS,
  localparam int MAX_ELEMS = GRP_BITS / MIN_SEW,
  localparam int VLW       = $clog2(MAX_ELEMS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           op,
  input  logic                 use_imm,
  input  logic [4:0]           imm,
  input  logic [63:0]          xoff,
  input  logic [63:0]          scalar,
  input  logic [VLW-1:0]       vl,
  input  logic [VLW-1:0]       vstart,
  input  logic [1:0]           sew_sel,
  input  logic [MAX_ELEMS-1:0] mask,
  input  logic                 mask_en,
  input  logic [4:0]           vd_idx,
  input  logic [4:0]           vs2_idx,
  input  logic [GRP_BITS-1:0]  old_vd,
  input  logic [GRP_BITS-1:0]  src,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [GRP_BITS-1:0]  out_res,
  output logic                 out_illegal
);
  sld_op_e             op_e;
  logic [63:0]         off;
  logic [GRP_BITS-1:0] lane_res [NUM_SEW];
  logic [GRP_BITS-1:0] next_res;
  logic                illegal;

  assign op_e = sld_op_e'(op);
  assign off  = use_imm ? {59'd0, imm} : xoff;

  for (genvar s = 0; s < NUM_SEW; s++) begin : g_sew
    vslide_lane #(
      .GRP_BITS (GRP_BITS),
      .SEW      (MIN_SEW << s),
      .MAX_ELEMS(MAX_ELEMS),
      .VLW      (VLW)
    ) lane_i (
      .op     (op_e),
      .off    (off),
      .scalar (scalar),
      .vl     (vl),
      .vstart (vstart),
      .mask   (mask),
      .mask_en(mask_en),
      .old_vd (old_vd),
      .src    (src),
      .res    (lane_res[s])
    );
  end

  vslide_legal #(.GROUP_REGS(GROUP_REGS)) legal_i (
    .op     (op_e),
    .mask_en(mask_en),
    .vd_idx (vd_idx),
    .vs2_idx(vs2_idx),
    .illegal(illegal)
  );

  assign next_res = illegal ? old_vd : lane_res[sew_sel];

  vslide_outreg #(.W(GRP_BITS)) out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d_res    (next_res),
    .d_ill    (illegal),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_res  (out_res),
    .out_ill  (out_illegal)
  );
endmodule

// File: rtl/vslide_unit_chk.sv
module vslide_unit_chk #(
  parameter int REG_BITS   = 128,
  parameter int GROUP_REGS = 2,
  localparam int GRP_BITS  = REG_BITS * GROUP_REGS,
  localparam int MAX_ELEMS = GRP_BITS / 8,
  localparam int VLW       = $clog2(MAX_ELEMS) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [1:0]           op,
  input logic                 use_imm,
  input logic [4:0]           imm,
  input logic [63:0]          xoff,
  input logic [63:0]          scalar,
  input logic [VLW-1:0]       vl,
  input logic [VLW-1:0]       vstart,
  input logic [1:0]           sew_sel,
  input logic [MAX_ELEMS-1:0] mask,
  input logic                 mask_en,
  input logic [4:0]           vd_idx,
  input logic [4:0]           vs2_idx,
  input logic [GRP_BITS-1:0]  old_vd,
  input logic [GRP_BITS-1:0]  src,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [GRP_BITS-1:0]  out_res,
  input logic                 out_illegal
);
  logic acc;
  int   vlmax;
  assign acc   = in_valid && in_ready;
  assign vlmax = MAX_ELEMS >> sew_sel;

  assert_vl_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (int'(vl) <= vlmax));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_illegal)));

  assert_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !op[0] && (vd_idx == vs2_idx)) |=> out_illegal);

  assert_down_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op[0] && (!mask_en || vd_idx != 5'd0)) |=> !out_illegal);

  assert_v0_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mask_en && vd_idx == 5'd0) |=> (out_illegal && out_res == $past(old_vd)));

  assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && vstart >= vl) |=> (out_res == $past(old_vd)));
endmodule

bind vslide_unit vslide_unit_chk #(.REG_BITS(REG_BITS), .GROUP_REGS(GROUP_REGS)) chk_i (.*);

// File: tb/vslide_unit_tb_top.sv
`timescale 1ns/1ps
module vslide_unit_tb_top;
  localparam int GB = 256;
  localparam int ME = 32;
  localparam int G  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] op = '0;
  logic use_imm = 1'b0;
  logic [4:0] imm = '0;
  logic [63:0] xoff = '0, scalar = '0;
  logic [5:0] vl = '0, vstart = '0;
  logic [1:0] sew_sel = '0;
  logic [ME-1:0] mask = '0;
  logic mask_en = 1'b0;
  logic [4:0] vd_idx = 5'd8, vs2_idx = 5'd16;
  logic [GB-1:0] old_vd = '0, src = '0;
  logic out_valid, out_ready = 1'b1;
  logic [GB-1:0] out_res;
  logic out_illegal;

  int checks = 0, errors = 0;
  string cur_req = "R11";
  bit rand_ready = 1'b0;
  bit last_acc = 1'b0;
  bit exp_valid = 1'b0, exp_ill = 1'b0;
  logic [GB-1:0] exp_res = '0;

  always #2.5 clk = ~clk;

  vslide_unit dut_i (.*);

  function automatic logic [GB-1:0] emask(int sw);
    return (GB'(1) << sw) - GB'(1);
  endfunction

  function automatic logic [GB-1:0] getel(logic [GB-1:0] v, int k, int sw);
    return (v >> (k*sw)) & emask(sw);
  endfunction

  // Reference model written from the requirements.
  task automatic model(output logic [GB-1:0] r, output bit il);
    int sw = 8 << sew_sel;
    int n  = GB / sw;
    longint unsigned o = use_imm ? longint'(imm) : xoff;
    logic [GB-1:0] val;
    bit ovl = (int'(vd_idx) < int'(vs2_idx) + G) && (int'(vs2_idx) < int'(vd_idx) + G);
    il = (mask_en && vd_idx == 0) || ((op == 2'd0 || op == 2'd2) && ovl);
    r = old_vd;
    if (il) return;
    for (int k = 0; k < n; k++) begin
      if (k >= int'(vstart) && k < int'(vl) && (!mask_en || mask[k])) begin
        val = getel(old_vd, k, sw);
        case (op)
          2'd0: if (o <= longint'(k)) val = getel(src, k - int'(o), sw);
          2'd1: if (o < longint'(n - k)) val = getel(src, k + int'(o), sw); else val = '0;
          2'd2: if (k == 0) val = GB'(scalar) & emask(sw); else val = getel(src, k-1, sw);
          default: if (k == int'(vl) - 1) val = GB'(scalar) & emask(sw);
                   else val = getel(src, k+1, sw);
        endcase
        r = (r & ~(emask(sw) << (k*sw))) | ((val & emask(sw)) << (k*sw));
      end
    end
  endtask

  always @(posedge clk) begin
    logic [GB-1:0] r;
    bit il;
    if (!rst_n) begin
      exp_valid = 0; exp_res = '0; exp_ill = 0; last_acc = 0;
    end else begin
      last_acc = in_valid && (!exp_valid || out_ready);
      if (last_acc) begin
        model(r, il);
        exp_valid = 1; exp_res = r; exp_ill = il;
      end else if (out_ready) exp_valid = 0;
    end
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (in_ready !== (!exp_valid || out_ready)) begin
        errors++;
        $display("FAIL R10 in_ready act=%0b exp=%0b", in_ready, !exp_valid || out_ready);
      end
      if (out_valid !== exp_valid) begin
        errors++;
        $display("FAIL R10 out_valid act=%0b exp=%0b", out_valid, exp_valid);
      end else if (exp_valid) begin
        checks++;
        if (out_res !== exp_res || out_illegal !== exp_ill) begin
          errors++;
          $display("FAIL %s res act=%h ill=%0b exp=%h ill=%0b", cur_req, out_res, out_illegal,
                   exp_res, exp_ill);
        end
      end
    end
  end

  always @(negedge clk) if (rand_ready) begin
    #1 out_ready = ($urandom_range(0, 9) < 8);
  end

  task automatic send();
    in_valid = 1'b1;
    do @(negedge clk); while (!last_acc);
    #1 in_valid = 1'b0;
  endtask

  task automatic setup(string req, logic [1:0] o, logic [1:0] s, int vlen, int vst);
    @(negedge clk); #1;
    cur_req = req; op = o; sew_sel = s; vl = 6'(vlen); vstart = 6'(vst);
    use_imm = 0; imm = '0; xoff = '0; mask_en = 0; mask = '1;
    vd_idx = 5'd8; vs2_idx = 5'd16;
    for (int b = 0; b < GB/32; b++) begin
      old_vd[b*32 +: 32] = 32'hAAAA_0000 | 32'(b);
      src[b*32 +: 32]    = 32'h5500_1100 + 32'(b * 32'h0404_0404);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_res !== '0 || out_illegal !== 0) begin
      errors++;
      $display("FAIL R11 reset act=%0b/%0b exp=0/0", out_valid, out_illegal);
    end
    rst_n = 1'b1;

    setup("R1", 2'd0, 2'd0, 10, 0); use_imm = 1; imm = 5'd3; send();
    setup("R2", 2'd1, 2'd0, 32, 0); xoff = 64'd5; send();
    setup("R3", 2'd2, 2'd1, 16, 0); scalar = 64'hFFFF_FFFF_ABCD_1234; send();
    setup("R4", 2'd3, 2'd2, 5, 0); scalar = 64'h1111_2222_3333_4444; send();
    setup("R5", 2'd1, 2'd0, 32, 0); xoff = 64'h1_0000_0000; send();
    setup("R5", 2'd1, 2'd0, 32, 0); use_imm = 1; imm = 5'd31; xoff = 64'h1_0000_0000; send();
    setup("R6", 2'd0, 2'd3, 4, 0); xoff = 64'd1; send();
    setup("R7", 2'd1, 2'd0, 20, 4); mask_en = 1; mask = 32'hA5C3_0F96; xoff = 64'd2; send();
    setup("R7", 2'd2, 2'd0, 6, 6); scalar = 64'h77; send();
    setup("R8", 2'd0, 2'd0, 8, 0); vd_idx = 5'd8; vs2_idx = 5'd9; send();
    setup("R8", 2'd3, 2'd0, 8, 0); vd_idx = 5'd8; vs2_idx = 5'd9; send();
    setup("R9", 2'd1, 2'd0, 8, 0); mask_en = 1; vd_idx = 5'd0; send();

    setup("R10", 2'd0, 2'd0, 8, 0); out_ready = 0; send();
    repeat (4) @(negedge clk);
    #1 out_ready = 1;
    @(negedge clk);

    rand_ready = 1;
    for (int t = 0; t < 500; t++) begin
      int s = $urandom_range(0, 3);
      int n = 32 >> s;
      int v = $urandom_range(0, n);
      @(negedge clk); #1;
      op = 2'($urandom_range(0, 3));
      cur_req = (op == 0) ? "R1" : (op == 1) ? "R2" : (op == 2) ? "R3" : "R4";
      sew_sel = 2'(s); vl = 6'(v); vstart = 6'($urandom_range(0, n));
      use_imm = 1'($urandom_range(0, 1)); imm = 5'($urandom);
      xoff = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : 64'($urandom_range(0, n + 2));
      scalar = {$urandom, $urandom};
      mask = ME'($urandom); mask_en = ($urandom_range(0, 3) == 0);
      vd_idx = 5'($urandom); vs2_idx = 5'($urandom);
      for (int b = 0; b < GB/32; b++) begin
        old_vd[b*32 +: 32] = $urandom;
        src[b*32 +: 32] = $urandom;
      end
      send();
    end
    rand_ready = 0;
    repeat (3) @(negedge clk);
    #1 out_ready = 1;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule